// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a supervision counter that begins running as soon as reset is released. If software fails to restart it before the chosen interval runs out, it pulses a reset request for one clock cycle. Software reaches it through one 16-bit control register. A write is accepted only when it is a full 16-bit access whose upper byte holds the key 0x5A. Any other write attempt is treated as tampering: it raises the reset request at once and records a sticky violation bit.

The control register can freeze the counter, restart it, pick one of eight power-of-two intervals, and switch the block into a periodic interval-timer mode. In that mode an expiry sets an interval flag instead of requesting a reset, and counting carries on without a break. The bench drives the reset input directly. The reset request is an output for the system around the block.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `rd_data` reads 0x6903, and `rst_req` and `intv_flag` are 0. The read layout is: upper byte fixed at 0x69; lower byte bit 7 = violation, bit 6 = interval flag, bit 5 = hold, bit 4 = interval mode, bit 3 reads 0, bits 2:0 = interval select. Reset value of interval select is 3.
- R2: With no writes after reset, `rst_req` goes high for exactly one cycle after the 32768th clock edge that follows reset release.
- R3: A write with `wr_word`=1 and `wr_data[15:8]`=0x5A updates hold (bit 5), mode (bit 4) and interval select (bits 2:0) from the same bit positions. It does not pulse `rst_req`.
- R4: A write with `wr_word`=0, or with an upper byte other than 0x5A, pulses `rst_req` in the next cycle, sets the violation bit and leaves hold, mode and interval select unchanged.
- R5: While hold is 1 the counter is frozen. After hold is released, counting resumes from the frozen value.
- R6: A valid write with bit 3 set restarts the count from zero. Bit 3 always reads back 0.
- R7: Interval select values 0..7 give expiry after 2^6, 2^9, 2^13, 2^15, 2^19, 2^23, 2^27 and 2^31 counted clock edges.
- R8: With mode set, an expiry sets `intv_flag` and does not pulse `rst_req`. The counter wraps to zero and keeps running, so the flag is set again after each further interval.
- R9: A valid write with bit 7 set clears the violation bit. A valid write with bit 6 set clears the interval flag. When an expiry and a flag-clear write fall in the same cycle, the expiry wins.
- R10: A valid clear write in the same cycle as an expiry suppresses that expiry, and the full interval restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_word | input | 1 | 1 = full 16-bit access, 0 = byte access |
| wr_data | input | 16 | Write data: key in the upper byte, control bits in the lower byte |
| rd_data | output | 16 | Read value: 0x69 in the upper byte, control state in the lower byte |
| rst_req | output | 1 | One-cycle reset request on expiry or violation |
| intv_flag | output | 1 | Interval-mode expiry flag |

## Verification
A counter that is off by one edge moves the reset pulse by one cycle. The bench therefore samples `rst_req` on both the cycle before and the cycle of the expected expiry, for several interval selections and after hold and clear. A faulty key check or field update shows up in `rd_data` and `rst_req` one cycle after the offending write. A mode or wrap fault in interval mode shows up either as an unwanted reset pulse or as a second flag arriving at the wrong time, one interval later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] WR_KEY   = 8'h5A;
  localparam logic [7:0] RD_TAG   = 8'h69;
  localparam logic [2:0] SEL_INIT = 3'd3;

  typedef struct packed {
    logic       viol;
    logic       flag;
    logic       hold;
    logic       mode;
    logic       spare;
    logic [2:0] sel;
  } wd_ctrl_t;

  // log2 of the expiry count for each interval selection
  function automatic int unsigned span_log2(input logic [2:0] s);
    int unsigned r;
    case (s)
      3'd0:    r = 6;
      3'd1:    r = 9;
      3'd2:    r = 13;
      3'd3:    r = 15;
      3'd4:    r = 19;
      3'd5:    r = 23;
      3'd6:    r = 27;
      default: r = 31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic          flag_set,
  output wd_ctrl_t      ctrl_q,
  output logic          clr_s,
  output logic          bad_s
);
  localparam int KEY_LO = DW - 8;

  logic key_ok, good_s;

  always_comb begin
    key_ok = (wr_data[DW-1:KEY_LO] == WR_KEY);
    good_s = wr_en && wr_word && key_ok;
    bad_s  = wr_en && !good_s;
    clr_s  = good_s && wr_data[3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{viol: 1'b0, flag: 1'b0, hold: 1'b0, mode: 1'b0,
                  spare: 1'b0, sel: SEL_INIT};
    end else begin
      if (good_s) begin
        ctrl_q.sel  <= wr_data[2:0];
        ctrl_q.mode <= wr_data[4];
        ctrl_q.hold <= wr_data[5];
        if (wr_data[7]) ctrl_q.viol <= 1'b0;
        if (wr_data[6]) ctrl_q.flag <= 1'b0;
      end
      if (bad_s)    ctrl_q.viol <= 1'b1;
      if (flag_set) ctrl_q.flag <= 1'b1;
    end
  end

  assert_bad_sets_viol_R4: assert property (@(posedge clk) disable iff (rst)
    bad_s |=> ctrl_q.viol);

  assert_bad_keeps_fields_R4: assert property (@(posedge clk) disable iff (rst)
    bad_s |=> ($stable(ctrl_q.sel) && $stable(ctrl_q.mode) && $stable(ctrl_q.hold)));

  assert_flag_wins_R9: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> ctrl_q.flag);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       exp_s
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic             run;

  always_comb begin
    lim_m1 = (CNT_W'(1) << span_log2(sel_i)) - CNT_W'(1);
    run    = !hold_i;
    exp_s  = run && !clr_i && (cnt_q >= lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (run)      cnt_q <= exp_s ? '0 : cnt_q + CNT_W'(1);
  end

  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !clr_i) |=> $stable(cnt_q));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_word,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rst_req,
  output logic          intv_flag
);
  localparam int PAD_W = DW - 16;

  wd_ctrl_t ctrl_q;
  logic     clr_s, bad_s, exp_s, flag_set;

  assign flag_set = exp_s && ctrl_q.mode;

  wdog_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .wr_data  (wr_data),
    .flag_set (flag_set),
    .ctrl_q   (ctrl_q),
    .clr_s    (clr_s),
    .bad_s    (bad_s)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .hold_i (ctrl_q.hold),
    .clr_i  (clr_s),
    .sel_i  (ctrl_q.sel),
    .exp_s  (exp_s)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, RD_TAG, ctrl_q};
    end else begin : g_nopad
      assign rd_data = {RD_TAG, ctrl_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= bad_s || (exp_s && !ctrl_q.mode);
  end

  assign intv_flag = ctrl_q.flag;

  assert_flag_needs_mode_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(intv_flag) |-> $past(ctrl_q.mode));

  assert_clear_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> !rst_req);
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b1;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        rst_req;
  logic        intv_flag;

  int total = 0;
  int bad   = 0;
  int n_req = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_guard u_wdog_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req),
    .intv_flag(intv_flag)
  );

  always @(negedge clk) if (!rst && rst_req) n_req++;

  // word, data, expected read, expected reset pulse
  localparam logic [33:0] VEC [7] = '{
    {1'b1, 16'h5A21, 16'h6921, 1'b0},
    {1'b1, 16'h5A35, 16'h6935, 1'b0},
    {1'b0, 16'h5A02, 16'h69B5, 1'b1},
    {1'b1, 16'hA502, 16'h69B5, 1'b1},
    {1'b1, 16'h5AA5, 16'h6925, 1'b0},
    {1'b1, 16'h5A2F, 16'h6927, 1'b0},
    {1'b1, 16'h5A24, 16'h6924, 1'b0}
  };

  localparam int SPAN [3] = '{64, 512, 8192};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic word, input logic [15:0] d);
    wr_en = 1'b1; wr_word = word; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b1; wr_data = 16'h0000;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expiry lands n edges from now; check the edge before, the edge itself, and the one after
  task automatic expect_req(input int n, input string req);
    waitn(n - 1);
    chk(req, rst_req, 1'b0);
    waitn(1);
    chk(req, rst_req, 1'b1);
    waitn(1);
    chk(req, rst_req, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL all act=running exp=finished (watchdog)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rd", rd_data, 16'h6903);
    chk("R1 req", rst_req, 1'b0);
    chk("R1 flag", intv_flag, 1'b0);
    // R2 default interval of 32768 edges
    expect_req(32768, "R2");

    // register access vectors: R3, R4, R6, R9
    do_reset();
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][33], VEC[i][32:17]);
      chk($sformatf("R3/R4/R6/R9 vec%0d rd", i), rd_data, VEC[i][16:1]);
      chk($sformatf("R3/R4 vec%0d req", i), rst_req, VEC[i][0]);
      if (VEC[i][0]) begin
        waitn(1);
        chk($sformatf("R4 vec%0d pulse end", i), rst_req, 1'b0);
      end
    end

    // R7 interval selections
    for (int k = 0; k < 3; k++) begin
      do_reset();
      wr(1'b1, 16'h5A08 | 16'(k));
      expect_req(SPAN[k], $sformatf("R7 sel%0d", k));
    end

    // R5 hold freezes and resumes
    do_reset();
    wr(1'b1, 16'h5A08);
    waitn(30);
    wr(1'b1, 16'h5A20);
    base = n_req;
    waitn(100);
    chk("R5 no pulse while held", n_req, base);
    chk("R5 rd held", rd_data, 16'h6920);
    wr(1'b1, 16'h5A00);
    expect_req(33, "R5 resume");

    // R8 interval mode
    do_reset();
    wr(1'b1, 16'h5A18);
    base = n_req;
    waitn(63);
    chk("R8 flag before", intv_flag, 1'b0);
    waitn(1);
    chk("R8 flag set", intv_flag, 1'b1);
    chk("R8 rd", rd_data, 16'h6950);
    wr(1'b1, 16'h5A50);
    chk("R9 flag cleared", intv_flag, 1'b0);
    waitn(62);
    chk("R8 second flag early", intv_flag, 1'b0);
    waitn(1);
    chk("R8 second flag", intv_flag, 1'b1);
    chk("R8 no reset pulse", n_req, base);

    // R10 clear at the expiry edge
    do_reset();
    wr(1'b1, 16'h5A08);
    base = n_req;
    waitn(63);
    wr(1'b1, 16'h5A08);
    chk("R10 suppressed", rst_req, 1'b0);
    chk("R10 no pulse", n_req, base);
    expect_req(64, "R10 full restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule